// File: doc/BRIEF.md
# Parallel Counter Array with Atomic Snapshot Readout

The block holds a bank of free-running binary counters, one register per counter and no logic shared between them. Every counter advances by one on every clock and never stops. A programmable interval timer picks the instant at which all counters are copied together into a snapshot register array. The snapshot then leaves the block over a single serial data line, so a bank of many wide counters can be watched through three output pins while the counters keep running. A disturbance that changes a counter bit changes every later value of that counter, so each later snapshot still shows it.

A small control machine with two states sequences the readout. In `ST_RUN` no frame is being sent and the block waits for the interval timer to expire. The transition RUN→SHIFT fires on that expiry and takes a capture. In `ST_SHIFT` one snapshot bit leaves the block per cycle. When the last bit goes out, the machine takes one of two transitions. It goes SHIFT→RUN if the timer has not expired. It takes SHIFT→SHIFT (a back-to-back capture) if the timer expired during the frame. While a frame is being sent, the timer stops at its terminal value, so no capture can cut a frame short.

Top module: `cnt_snap_array`

## Requirements
- R1: After reset release, each counter holds the number of clock edges seen since release, modulo 2^CNT_W. A snapshot taken on edge E therefore carries (E-1) mod 2^CNT_W.
- R2: All counters reset to zero together, and all NUM_CNT fields of every snapshot frame are equal.
- R3: The interval timer starts at 0 after reset and after each capture. A capture is taken on the edge where the timer value is at or above `period_i`. With period P, the first capture falls on edge P+1, and `frm_o` is high in the cycle that follows that edge.
- R4: A frame has NUM_CNT*CNT_W bits on `sdat_o`. It sends counter 0 first and each counter most significant bit first. `sval_o` stays high for exactly that many consecutive cycles, and `frm_o` is high only with the first bit.
- R5: No capture is taken while a frame is partly sent. If the timer expires during a frame, the capture is taken on the edge that consumes the last bit, and the next frame follows with no gap. Captures are therefore spaced max(P+1, NUM_CNT*CNT_W) cycles apart.
- R6: During reset, and in every cycle in which `sval_o` is low, `sdat_o` and `frm_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_i | input | PER_W | Terminal value of the snapshot interval timer |
| sdat_o | output | 1 | Serial snapshot data |
| sval_o | output | 1 | High while a snapshot bit is on `sdat_o` |
| frm_o | output | 1 | High with the first bit of each snapshot frame |

## Verification
A capture on edge E is first visible in the cycle after E. In that cycle `frm_o` rises together with the most significant bit of counter 0, and the captured value is E-1. The bench counts edges from reset release. It samples all outputs on the falling edge, so the edge count read at the frame start is exactly E. The remaining bits follow one per falling edge, and the bench decodes them and compares them with E-1. The spacing between frame starts is compared with max(P+1, frame length), and the first frame start is compared with P+1.

// File: rtl/cnt_snap_pkg.sv
package cnt_snap_pkg;
    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_SHIFT = 1'b1
    } rd_state_e;
endpackage

// File: rtl/cnt_snap_bank.sv
module cnt_snap_bank #(
    parameter int NUM_CNT = 8,
    parameter int CNT_W   = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    output logic [NUM_CNT*CNT_W-1:0]   cnt_flat_o
);
    localparam int TOT = NUM_CNT * CNT_W;

    logic [CNT_W-1:0] cnt_q [NUM_CNT];

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n) cnt_q[g] <= '0;
            else        cnt_q[g] <= cnt_q[g] + 1'b1;
        end
        // counter 0 occupies the top field so it leaves the block first
        assign cnt_flat_o[TOT-1-g*CNT_W -: CNT_W] = cnt_q[g];

        if (g > 0) begin : g_eq
            // R2
            cnt_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q[g] == cnt_q[0]);
        end
    end
endmodule

// File: rtl/cnt_snap_ivl.sv
module cnt_snap_ivl #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period_i,
    input  logic             take_i,
    output logic             term_o
);
    logic [PER_W-1:0] ivl_q;

    assign term_o = (ivl_q >= period_i);

    always_ff @(posedge clk) begin
        if (!rst_n)       ivl_q <= '0;
        else if (take_i)  ivl_q <= '0;
        else if (!term_o) ivl_q <= ivl_q + 1'b1;
    end

    // R5
    ivl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (term_o && !take_i) |=> (term_o || $changed(period_i)));
endmodule

// File: rtl/cnt_snap_rd.sv
module cnt_snap_rd
    import cnt_snap_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int CNT_W   = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     term_i,
    input  logic [NUM_CNT*CNT_W-1:0] cnt_flat_i,
    output logic                     take_o,
    output logic                     sdat_o,
    output logic                     sval_o,
    output logic                     frm_o
);
    localparam int TOT  = NUM_CNT * CNT_W;
    localparam int BC_W = (TOT > 1) ? $clog2(TOT) : 1;
    localparam logic [BC_W-1:0] LAST = BC_W'(TOT - 1);

    rd_state_e        state_q, state_d;
    logic [TOT-1:0]   snap_q;
    logic [BC_W-1:0]  bit_q;
    logic             last_bit;

    assign last_bit = (bit_q == LAST);

    // next state and capture decision
    always_comb begin
        state_d = state_q;
        take_o  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (term_i) begin
                    take_o  = 1'b1;
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (last_bit) begin
                    if (term_i) take_o  = 1'b1;
                    else        state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // snapshot array doubles as the shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
            bit_q  <= '0;
        end else if (take_o) begin
            snap_q <= cnt_flat_i;
            bit_q  <= '0;
        end else if (state_q == ST_SHIFT) begin
            snap_q <= snap_q << 1;
            bit_q  <= bit_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        sval_o = (state_q == ST_SHIFT);
        frm_o  = sval_o && (bit_q == '0);
        sdat_o = sval_o && snap_q[TOT-1];
    end

    // R4
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sval_o) |-> $past(bit_q) == LAST);

    // R5
    shift_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sval_o && !last_bit) |=> (sval_o && !frm_o));
endmodule

// File: rtl/cnt_snap_array.sv
module cnt_snap_array #(
    parameter int NUM_CNT = 8,
    parameter int CNT_W   = 24,
    parameter int PER_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period_i,
    output logic             sdat_o,
    output logic             sval_o,
    output logic             frm_o
);
    localparam int TOT = NUM_CNT * CNT_W;

    logic [TOT-1:0] cnt_flat;
    logic           term;
    logic           take;

    cnt_snap_bank #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_flat_o (cnt_flat)
    );

    cnt_snap_ivl #(.PER_W(PER_W)) u_ivl (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (period_i),
        .take_i   (take),
        .term_o   (term)
    );

    cnt_snap_rd #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .term_i     (term),
        .cnt_flat_i (cnt_flat),
        .take_o     (take),
        .sdat_o     (sdat_o),
        .sval_o     (sval_o),
        .frm_o      (frm_o)
    );

    // R3
    cap_frm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (frm_o && sval_o));

    // R6
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sval_o |-> (!sdat_o && !frm_o));
endmodule

// File: tb/cnt_snap_array_tb_top.sv
`timescale 1ns/1ps
module cnt_snap_array_tb_top;
    localparam int NC  = 4;
    localparam int CW  = 10;
    localparam int PW  = 16;
    localparam int TOT = NC * CW;
    localparam int MOD = 1 << CW;

    // period, expected first frame start edge, expected frame spacing
    localparam int NV = 5;
    localparam int TV [NV][3] = '{
        '{  0,   1,  40},
        '{ 10,  11,  40},
        '{ 39,  40,  40},
        '{ 50,  51,  51},
        '{100, 101, 101}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] period = '0;
    logic          sdat, sval, frm;
    int            cyc;
    int            n_run = 0;
    int            n_fail = 0;

    always #2.5 clk = ~clk;

    always_ff @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    cnt_snap_array #(.NUM_CNT(NC), .CNT_W(CW), .PER_W(PW)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (period),
        .sdat_o   (sdat),
        .sval_o   (sval),
        .frm_o    (frm)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int p);
        @(negedge clk);
        rst_n  = 1'b0;
        period = PW'(p);
        repeat (3) @(negedge clk);
        // R6 outputs low in reset
        chk(!sval && !sdat && !frm, "R6 reset outputs", {sval, sdat, frm}, 0);
        rst_n = 1'b1;
    endtask

    // waits for a frame start, returns its edge index and all bits
    task automatic get_frame(output int st, output logic [TOT-1:0] bits, output bit shape_ok);
        shape_ok = 1'b1;
        st = -1;
        bits = '0;
        for (int w = 0; w < 5000; w++) begin
            @(negedge clk);
            if (frm) begin
                st = cyc;
                break;
            end
        end
        if (st < 0) begin
            shape_ok = 1'b0;
            return;
        end
        bits[TOT-1] = sdat;
        for (int j = 1; j < TOT; j++) begin
            @(negedge clk);
            if (!sval || frm) shape_ok = 1'b0;
            bits[TOT-1-j] = sdat;
        end
    endtask

    task automatic chk_vals(input logic [TOT-1:0] bits, input int st);
        int exp_v;
        exp_v = (st - 1) % MOD;
        for (int k = 0; k < NC; k++) begin
            logic [CW-1:0] v;
            v = bits[TOT-1-k*CW -: CW];
            // R1 value = edges before capture edge; R2 fields equal
            chk(int'(v) == exp_v, (k == 0) ? "R1 snapshot value" : "R2 field equal",
                int'(v), exp_v);
        end
    endtask

    initial begin : watchdog
        #(150000 * 5);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        int st1, st2;
        logic [TOT-1:0] b1, b2;
        bit ok1, ok2;

        // table walk
        for (int i = 0; i < NV; i++) begin
            do_reset(TV[i][0]);
            get_frame(st1, b1, ok1);
            chk(st1 == TV[i][1], "R3 first capture edge", st1, TV[i][1]);
            chk(ok1, "R4 frame shape", ok1, 1);
            chk_vals(b1, st1);
            get_frame(st2, b2, ok2);
            chk(st2 - st1 == TV[i][2], "R5 capture spacing", st2 - st1, TV[i][2]);
            chk(ok2, "R4 frame shape", ok2, 1);
            chk_vals(b2, st2);
        end

        // R6 idle outputs low before the first capture
        do_reset(200);
        begin
            bit idle_ok;
            idle_ok = 1'b1;
            for (int c = 0; c < 150; c++) begin
                @(negedge clk);
                if (sval || sdat || frm) idle_ok = 1'b0;
            end
            chk(idle_ok, "R6 idle outputs", idle_ok, 1);
        end

        // R1 wrap: period past the counter range
        do_reset(1030);
        get_frame(st1, b1, ok1);
        chk(st1 == 1031, "R3 first capture edge", st1, 1031);
        chk(int'(b1[TOT-1 -: CW]) == 6, "R1 wrap value", int'(b1[TOT-1 -: CW]), 6);
        chk_vals(b1, st1);

        // R1 wrap over a full lap between frames
        do_reset(1023);
        get_frame(st1, b1, ok1);
        get_frame(st2, b2, ok2);
        chk(int'(b2[TOT-1 -: CW]) == 1023, "R1 full lap value", int'(b2[TOT-1 -: CW]), 1023);
        chk(st2 - st1 == 1024, "R5 capture spacing", st2 - st1, 1024);
        chk_vals(b2, st2);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule